// File: doc/BRIEF.md
# Tagged-Operand Floating-Point Multiplier

This block multiplies two floating-point operands that arrive in an internal hardware form rather than in the packed interchange encoding. Each operand is split into a sign, a biased exponent, a fraction without its leading one, and a two-bit class tag. The tag alone says whether the operand is zero, a normal number, an infinity or not-a-number. No exponent or fraction pattern has to be decoded to find special values. Values too small to be normal are flushed to signed zero, on the way in and on the way out.

The datapath runs as a fixed three-stage pipeline that accepts one operation per clock. The first stage classifies the operands and forms the full significand product, hidden bits included. The second stage normalizes the product and rounds it. The third stage checks the exponent range and registers the tagged result. A parameter fixed at elaboration selects the rounding: round to nearest with ties to even, or plain truncation toward zero. In truncation mode the bits below the kept fraction are never examined, so no round or sticky logic is built. The defaults give single precision (8 exponent bits, 23 fraction bits), and the widths are parameters.

Top module: `fpm_tagmul`

## Requirements
- R1: A normal operand has the value (-1)^sign × 1.frac × 2^(exp − bias), with bias = 2^(EXP_W−1) − 1. When both operands are normal and the significand product fits the result width exactly, the result is that exact product.
- R2: Tag codes are 00 zero, 01 normal, 10 infinity and 11 NaN. Every result whose tag is not normal has its exponent and fraction fields all zero.
- R3: The result is NaN when either operand is NaN, and when one operand is zero and the other is infinity.
- R4: Infinity times a normal number or an infinity gives infinity. Zero times a normal number or a zero gives zero.
- R5: The result sign is the XOR of the two operand signs for every class of result, NaN included.
- R6: An operand tagged normal whose exponent field is 0 is treated as zero.
- R7: With ROUND_NEAREST=1, an inexact normal product is rounded to the nearest representable value, and a tie goes to the even fraction.
- R8: With ROUND_NEAREST=0, an inexact normal product is truncated toward zero and the discarded bits have no effect.
- R9: When rounding carries out of the fraction, the result fraction becomes 0 and the exponent rises by one.
- R10: A rounded exponent above 2^EXP_W − 2 gives infinity.
- R11: A rounded exponent below 1 gives zero.
- R12: The result of an operation presented with in_valid high appears three clock edges later with out_valid high. A new operation can be accepted on every cycle, and out_valid is low in every cycle that carries no result.
- R13: While rst is high at a clock edge, out_valid is cleared and the result tag is set to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair is valid this cycle |
| a_sign | input | 1 | Sign of operand A |
| a_exp | input | EXP_W | Biased exponent of operand A |
| a_frac | input | FRAC_W | Fraction of operand A, without the hidden bit |
| a_tag | input | 2 | Class tag of operand A |
| b_sign | input | 1 | Sign of operand B |
| b_exp | input | EXP_W | Biased exponent of operand B |
| b_frac | input | FRAC_W | Fraction of operand B, without the hidden bit |
| b_tag | input | 2 | Class tag of operand B |
| out_valid | output | 1 | Result is valid this cycle |
| z_sign | output | 1 | Result sign |
| z_exp | output | EXP_W | Result biased exponent (zero for non-normal results) |
| z_frac | output | FRAC_W | Result fraction (zero for non-normal results) |
| z_tag | output | 2 | Result class tag |

## Verification
The assertions assume that in_valid and every operand field are driven to known values after reset. They also assume that an operand tagged normal never carries the all-ones exponent, which belongs to no class. The stimulus sweeps exponent fields only from 0 to 2^EXP_W − 2 in a reduced configuration (4 exponent bits, 3 fraction bits). It gives every tag combination fixed, legal exponent values, so the bench stays inside the assumed input space while still reaching overflow, underflow, rounding carries and the zero-exponent flush. The bench also drops in_valid at regular intervals, so the pipeline's valid tracking is exercised with gaps as well as back-to-back operations.

// File: rtl/fpm_pkg.sv
`timescale 1ns/1ps
package fpm_pkg;

  // Two-bit class tag carried beside each operand and result
  typedef enum logic [1:0] {
    TAG_ZERO = 2'b00,
    TAG_NORM = 2'b01,
    TAG_INF  = 2'b10,
    TAG_NAN  = 2'b11
  } fp_tag_e;

endpackage

// File: rtl/fpm_classify.sv
`timescale 1ns/1ps
// Resolves the result class from operand tags; flags the case needing arithmetic.
module fpm_classify #(
  parameter int EXP_W = 8
) (
  input  logic [1:0]       a_tag,
  input  logic [EXP_W-1:0] a_exp,
  input  logic [1:0]       b_tag,
  input  logic [EXP_W-1:0] b_exp,
  output fpm_pkg::fp_tag_e spec_tag,
  output logic             both_norm
);
  import fpm_pkg::*;

  fp_tag_e eff_a, eff_b;

  // A normal tag with a zero exponent field would be subnormal: flush it.
  always_comb begin
    eff_a = fp_tag_e'(a_tag);
    eff_b = fp_tag_e'(b_tag);
    if (eff_a == TAG_NORM && a_exp == '0) eff_a = TAG_ZERO;
    if (eff_b == TAG_NORM && b_exp == '0) eff_b = TAG_ZERO;
  end

  always_comb begin
    both_norm = 1'b0;
    if (eff_a == TAG_NAN || eff_b == TAG_NAN)
      spec_tag = TAG_NAN;
    else if ((eff_a == TAG_ZERO && eff_b == TAG_INF) ||
             (eff_a == TAG_INF  && eff_b == TAG_ZERO))
      spec_tag = TAG_NAN;
    else if (eff_a == TAG_INF || eff_b == TAG_INF)
      spec_tag = TAG_INF;
    else if (eff_a == TAG_ZERO || eff_b == TAG_ZERO)
      spec_tag = TAG_ZERO;
    else begin
      spec_tag  = TAG_NORM;
      both_norm = 1'b1;
    end
  end

endmodule

// File: rtl/fpm_sigmul.sv
`timescale 1ns/1ps
// Full-width product of the two significands with hidden ones restored.
module fpm_sigmul #(
  parameter int FRAC_W = 23,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int PROD_W = 2 * SIG_W
) (
  input  logic [FRAC_W-1:0] a_frac,
  input  logic [FRAC_W-1:0] b_frac,
  output logic [PROD_W-1:0] prod
);
  logic [SIG_W-1:0] sig_a, sig_b;

  assign sig_a = {1'b1, a_frac};
  assign sig_b = {1'b1, b_frac};
  assign prod  = PROD_W'(sig_a) * PROD_W'(sig_b);

endmodule

// File: rtl/fpm_round.sv
`timescale 1ns/1ps
// Normalizes a product in [1,4) to [1,2) and rounds it to FRAC_W bits.
module fpm_round #(
  parameter int FRAC_W        = 23,
  parameter int EXT_W         = 10,
  parameter bit ROUND_NEAREST = 1'b1,
  localparam int PROD_W = 2 * (FRAC_W + 1)
) (
  input  logic [PROD_W-1:0]       prod,
  input  logic signed [EXT_W-1:0] exp_in,
  output logic [FRAC_W-1:0]       frac_out,
  output logic signed [EXT_W-1:0] exp_out
);
  logic                    hi;
  logic [PROD_W-2:0]       norm;
  logic [FRAC_W-1:0]       keep;
  logic signed [EXT_W-1:0] exp_adj;

  assign hi      = prod[PROD_W-1];
  // Drop the leading one; shift left once when the product is below 2.
  assign norm    = hi ? prod[PROD_W-2:0] : {prod[PROD_W-3:0], 1'b0};
  assign keep    = norm[PROD_W-2 -: FRAC_W];
  assign exp_adj = exp_in + EXT_W'(hi);

  generate
    if (ROUND_NEAREST) begin : g_rne
      localparam int REST_W = PROD_W - 1 - FRAC_W;
      logic [REST_W-1:0] rest;
      logic              rbit, sticky, bump;
      logic [FRAC_W:0]   sum;

      assign rest     = norm[REST_W-1:0];
      assign rbit     = rest[REST_W-1];
      assign sticky   = |rest[REST_W-2:0];
      assign bump     = rbit & (sticky | keep[0]);
      assign sum      = {1'b0, keep} + (FRAC_W+1)'(bump);
      assign frac_out = sum[FRAC_W-1:0];
      assign exp_out  = exp_adj + EXT_W'(sum[FRAC_W]);
    end else begin : g_trunc
      assign frac_out = keep;
      assign exp_out  = exp_adj;
    end
  endgenerate

endmodule

// File: rtl/fpm_tagmul.sv
`timescale 1ns/1ps
// Three-stage tagged floating-point multiplier.
module fpm_tagmul #(
  parameter int EXP_W         = 8,
  parameter int FRAC_W        = 23,
  parameter bit ROUND_NEAREST = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              a_sign,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic [FRAC_W-1:0] a_frac,
  input  logic [1:0]        a_tag,
  input  logic              b_sign,
  input  logic [EXP_W-1:0]  b_exp,
  input  logic [FRAC_W-1:0] b_frac,
  input  logic [1:0]        b_tag,
  output logic              out_valid,
  output logic              z_sign,
  output logic [EXP_W-1:0]  z_exp,
  output logic [FRAC_W-1:0] z_frac,
  output logic [1:0]        z_tag
);
  import fpm_pkg::*;

  localparam int PROD_W = 2 * (FRAC_W + 1);
  localparam int EXT_W  = EXP_W + 2;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX   = (1 << EXP_W) - 2;
  localparam logic signed [EXT_W-1:0] EMAX_X = EXT_W'(EMAX);
  localparam logic signed [EXT_W-1:0] EMIN_X = EXT_W'(1);

  // ---------------- stage 1: classify and multiply ----------------
  fp_tag_e                 spec_c;
  logic                    num_c;
  logic [PROD_W-1:0]       prod_c;
  logic signed [EXT_W-1:0] esum_c;

  fpm_classify #(.EXP_W(EXP_W)) u_cls (
    .a_tag(a_tag), .a_exp(a_exp), .b_tag(b_tag), .b_exp(b_exp),
    .spec_tag(spec_c), .both_norm(num_c)
  );

  fpm_sigmul #(.FRAC_W(FRAC_W)) u_mul (
    .a_frac(a_frac), .b_frac(b_frac), .prod(prod_c)
  );

  assign esum_c = EXT_W'(a_exp) + EXT_W'(b_exp) - EXT_W'(BIAS);

  logic                    v1, s1, n1;
  fp_tag_e                 t1;
  logic [PROD_W-1:0]       p1;
  logic signed [EXT_W-1:0] e1;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      s1 <= 1'b0;
      n1 <= 1'b0;
      t1 <= TAG_ZERO;
      p1 <= '0;
      e1 <= '0;
    end else begin
      v1 <= in_valid;
      s1 <= a_sign ^ b_sign;
      n1 <= num_c;
      t1 <= spec_c;
      p1 <= prod_c;
      e1 <= esum_c;
    end
  end

  // ---------------- stage 2: normalize and round ----------------
  logic [FRAC_W-1:0]       frac_c;
  logic signed [EXT_W-1:0] erd_c;

  fpm_round #(
    .FRAC_W(FRAC_W), .EXT_W(EXT_W), .ROUND_NEAREST(ROUND_NEAREST)
  ) u_rnd (
    .prod(p1), .exp_in(e1), .frac_out(frac_c), .exp_out(erd_c)
  );

  logic                    v2, s2, n2;
  fp_tag_e                 t2;
  logic [FRAC_W-1:0]       f2;
  logic signed [EXT_W-1:0] e2;

  always_ff @(posedge clk) begin
    if (rst) begin
      v2 <= 1'b0;
      s2 <= 1'b0;
      n2 <= 1'b0;
      t2 <= TAG_ZERO;
      f2 <= '0;
      e2 <= '0;
    end else begin
      v2 <= v1;
      s2 <= s1;
      n2 <= n1;
      t2 <= t1;
      f2 <= frac_c;
      e2 <= erd_c;
    end
  end

  // ---------------- stage 3: range check and output ----------------
  fp_tag_e           tag_c;
  logic [EXP_W-1:0]  zexp_c;
  logic [FRAC_W-1:0] zfrac_c;

  always_comb begin
    tag_c   = t2;
    zexp_c  = '0;
    zfrac_c = '0;
    if (n2) begin
      if (e2 > EMAX_X)
        tag_c = TAG_INF;
      else if (e2 < EMIN_X)
        tag_c = TAG_ZERO;
      else begin
        tag_c   = TAG_NORM;
        zexp_c  = e2[EXP_W-1:0];
        zfrac_c = f2;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      z_sign    <= 1'b0;
      z_exp     <= '0;
      z_frac    <= '0;
      z_tag     <= TAG_ZERO;
    end else begin
      out_valid <= v2;
      z_sign    <= s2;
      z_exp     <= zexp_c;
      z_frac    <= zfrac_c;
      z_tag     <= tag_c;
    end
  end

endmodule

// File: rtl/fpm_tagmul_chk.sv
`timescale 1ns/1ps
module fpm_tagmul_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              a_sign,
  input logic [1:0]        a_tag,
  input logic              b_sign,
  input logic [1:0]        b_tag,
  input logic              out_valid,
  input logic              z_sign,
  input logic [EXP_W-1:0]  z_exp,
  input logic [FRAC_W-1:0] z_frac,
  input logic [1:0]        z_tag
);
  // Counts edges since reset so that 3-deep history is only used once filled
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R12
  a_r12_latency: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R5
  a_r5_sign_xor: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && out_valid) |-> (z_sign == $past(a_sign ^ b_sign, 3)));

  // R3
  a_r3_nan_in: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && out_valid && $past(a_tag == 2'b11 || b_tag == 2'b11, 3))
      |-> (z_tag == 2'b11));

  // R3
  a_r3_zero_inf: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && out_valid &&
     $past((a_tag == 2'b00 && b_tag == 2'b10) || (a_tag == 2'b10 && b_tag == 2'b00), 3))
      |-> (z_tag == 2'b11));

  // R2
  a_r2_special_fields: assert property (@(posedge clk) disable iff (rst)
    (out_valid && z_tag != 2'b01) |-> (z_exp == '0 && z_frac == '0));

  // R10, R11
  a_r10_r11_exp_range: assert property (@(posedge clk) disable iff (rst)
    (out_valid && z_tag == 2'b01) |-> (z_exp != '0 && z_exp != '1));

endmodule

bind fpm_tagmul fpm_tagmul_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .a_sign(a_sign), .a_tag(a_tag), .b_sign(b_sign), .b_tag(b_tag),
  .out_valid(out_valid), .z_sign(z_sign), .z_exp(z_exp),
  .z_frac(z_frac), .z_tag(z_tag)
);

// File: tb/tb_fpm_tagmul.sv
`timescale 1ns/1ps
module tb_fpm_tagmul;
  localparam int EW   = 4;
  localparam int FW   = 3;
  localparam int RW   = 2 + 1 + EW + FW;
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam int EMAX = (1 << EW) - 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          in_valid = 1'b0;
  logic          a_sign = 1'b0, b_sign = 1'b0;
  logic [EW-1:0] a_exp = '0, b_exp = '0;
  logic [FW-1:0] a_frac = '0, b_frac = '0;
  logic [1:0]    a_tag = '0, b_tag = '0;

  logic          ov_n, zs_n, ov_t, zs_t;
  logic [EW-1:0] ze_n, ze_t;
  logic [FW-1:0] zf_n, zf_t;
  logic [1:0]    zt_n, zt_t;

  fpm_tagmul #(.EXP_W(EW), .FRAC_W(FW), .ROUND_NEAREST(1'b1)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_sign(a_sign), .a_exp(a_exp), .a_frac(a_frac), .a_tag(a_tag),
    .b_sign(b_sign), .b_exp(b_exp), .b_frac(b_frac), .b_tag(b_tag),
    .out_valid(ov_n), .z_sign(zs_n), .z_exp(ze_n), .z_frac(zf_n), .z_tag(zt_n)
  );

  fpm_tagmul #(.EXP_W(EW), .FRAC_W(FW), .ROUND_NEAREST(1'b0)) dut_tz (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_sign(a_sign), .a_exp(a_exp), .a_frac(a_frac), .a_tag(a_tag),
    .b_sign(b_sign), .b_exp(b_exp), .b_frac(b_frac), .b_tag(b_tag),
    .out_valid(ov_t), .z_sign(zs_t), .z_exp(ze_t), .z_frac(zf_t), .z_tag(zt_t)
  );

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  task automatic chk(input string req, input logic [RW-1:0] act, input logic [RW-1:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // Arithmetic reference: returns {tag, sign, exp, frac} and the requirement it exercises
  function automatic logic [RW-1:0] model(
    input bit rne, input bit sa, input int ea, input int fa, input int ta,
    input bit sb, input int eb, input int fb, input int tb, output string lbl);
    int tae, tbe, tag, e, p, k, q, rem, half, ez, fz;
    bit s;
    s   = sa ^ sb;
    tae = (ta == 1 && ea == 0) ? 0 : ta;
    tbe = (tb == 1 && eb == 0) ? 0 : tb;
    ez = 0; fz = 0;
    if (tae == 3 || tbe == 3 || (tae == 0 && tbe == 2) || (tae == 2 && tbe == 0)) begin
      tag = 3; lbl = "R3";
    end else if (tae == 2 || tbe == 2) begin
      tag = 2; lbl = "R4";
    end else if (tae == 0 || tbe == 0) begin
      tag = 0; lbl = (ta != tae || tb != tbe) ? "R6" : "R4";
    end else begin
      e = ea + eb - BIAS;
      p = ((1 << FW) + fa) * ((1 << FW) + fb);
      k = FW;
      if (p >= (1 << (2 * FW + 1))) begin k = FW + 1; e++; end
      q    = p >> k;
      rem  = p - (q << k);
      half = 1 << (k - 1);
      lbl  = rne ? "R7" : "R8";
      if (rem == 0) lbl = "R1";
      if (rne && (rem > half || (rem == half && (q % 2) == 1))) q++;
      if (q == (1 << (FW + 1))) begin q = 1 << FW; e++; lbl = "R9"; end
      if (e > EMAX) begin tag = 2; lbl = "R10"; end
      else if (e < 1) begin tag = 0; lbl = "R11"; end
      else begin tag = 1; ez = e; fz = q - (1 << FW); end
    end
    return {2'(tag), s, EW'(ez), FW'(fz)};
  endfunction

  // Expected results for the operation driven three negedges earlier
  logic  hv [4];
  logic [RW-1:0] hn [4], ht [4];
  string ln [4], lt [4];
  int    cyc = 0;

  task automatic step(input bit v, input bit sa, input int ea, input int fa, input int ta,
                      input bit sb, input int eb, input int fb, input int tb);
    int    old, cur;
    string l1, l2;
    logic [RW-1:0] gn, gt;
    old = (cyc + 1) % 4;
    cur = cyc % 4;
    // check result due now
    gn = {zt_n, zs_n, ze_n, zf_n};
    gt = {zt_t, zs_t, ze_t, zf_t};
    chk("R12 valid (nearest)", RW'(ov_n), RW'(hv[old]));
    chk("R12 valid (trunc)",   RW'(ov_t), RW'(hv[old]));
    if (hv[old]) begin
      chk({ln[old], " nearest"}, gn, hn[old]);
      chk({lt[old], " trunc"},   gt, ht[old]);
      chk("R5 sign", RW'(zs_n), RW'(hn[old][EW+FW]));
    end
    // drive the next operation
    in_valid <= v;
    a_sign <= sa; a_exp <= EW'(ea); a_frac <= FW'(fa); a_tag <= 2'(ta);
    b_sign <= sb; b_exp <= EW'(eb); b_frac <= FW'(fb); b_tag <= 2'(tb);
    hv[cur] = v;
    hn[cur] = model(1'b1, sa, ea, fa, ta, sb, eb, fb, tb, l1);
    ht[cur] = model(1'b0, sa, ea, fa, ta, sb, eb, fb, tb, l2);
    ln[cur] = l1;
    lt[cur] = l2;
    cyc++;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin hv[i] = 1'b0; hn[i] = '0; ht[i] = '0; ln[i] = ""; lt[i] = ""; end
    // R13: reset clears the pipeline even while in_valid is high
    in_valid = 1'b1; a_tag = 2'b11; b_tag = 2'b11;
    repeat (4) @(negedge clk);
    chk("R13 out_valid in reset", RW'(ov_n), RW'(0));
    chk("R13 tag in reset", RW'(zt_n), RW'(0));
    chk("R13 trunc out_valid in reset", RW'(ov_t), RW'(0));
    in_valid = 1'b0;
    rst = 1'b0;
    // Exhaustive sweep of normal-tagged operands (exponent 0 exercises R6)
    for (int ia = 0; ia < (EMAX + 1) * (1 << FW); ia++) begin
      for (int ib = 0; ib < (EMAX + 1) * (1 << FW); ib++) begin
        @(negedge clk);
        step(((ia + ib) % 16) != 5, ia[0], ia >> FW, ia % (1 << FW), 1,
             ib[1], ib >> FW, ib % (1 << FW), 1);
      end
    end
    // Every tag pair with both signs (R2, R3, R4, R5)
    for (int ta = 0; ta < 4; ta++)
      for (int tb = 0; tb < 4; tb++)
        for (int sa = 0; sa < 2; sa++)
          for (int sb = 0; sb < 2; sb++)
            for (int ez = 0; ez < 2; ez++) begin
              @(negedge clk);
              step(1'b1, sa[0], ez ? BIAS : 0, 3, ta, sb[0], BIAS + 1, 5, tb);
            end
    // Drain with idle cycles
    for (int d = 0; d < 4; d++) begin
      @(negedge clk);
      step(1'b0, 0, 0, 0, 0, 0, 0, 0, 0);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule